// File: doc/BRIEF.md
# Array access address generation unit

This block turns indexed store operations into memory store requests. It holds four register files. The first has 32 array descriptors, each with a 48-bit base, a 3-bit tag field and a 2-bit access field. The other three are 16 current-index registers, 16 index registers and 8 increment registers, and each of their entries carries one tag bit. For each store the unit decodes the operation word and forms the address from the descriptor base, the sign-extended current index and an optional literal. It then issues a one-cycle store request that carries the byte size. When asked, it advances the current index by the increment times the access size.

When the access code is 0x3F the same operation becomes a register write instead. It loads a descriptor or one entry of the index files from the operation data, and records whether the data tag was nonzero. Three things are evaluated outside the block and arrive on input pins: the predicate condition that gates the post-increment, the presence and values of the literal slots, and the write-permission probe used in speculative mode.

Each store request also reports the attributes of the operands it used: the descriptor tag field and access field, the three register tag bits, and the value of the selected index register.

Top module: `aau_store_unit`

## Requirements
- R1: After reset all registers read as zero, except increment register 0, which reads 1. st_valid and exc_illop are 0, so a doubleword store through descriptor 0 and current index 0 gives address 0.
- R2: The operation word holds these fields: literal selector in bits 9:8, sub-opcode in 11:10, increment number in 14:12, index number in 18:15 and descriptor number in 23:19. The store address is the descriptor base, plus the 32-bit current-index register sign-extended to 48 bits, plus the zero-extended 32-bit literal, taken modulo 2^48. Selector 0 adds no literal, and selector N adds slot N-1 (bits 32(N-1)+31 down to 32(N-1) of lit_value).
- R3: A store whose literal selector is nonzero and whose slot's lit_present bit is 0 raises exc_illop for one cycle. It issues no store and does not increment.
- R4: Opcodes 0x1C, 0x1D, 0x1E and 0x1F give st_size 1, 2, 4 and 8. st_data is op_data with every byte above the size cleared. Any other opcode has no effect.
- R5: The store request appears on the clock edge that accepts the operation: st_valid is high in the cycle after op_valid and lasts one cycle.
- R6: When sub-opcode bit 0 is 1 and cond_en is 1, the current-index register is increased by the increment register times the size, wrapping at 32 bits. Its tag bit is left unchanged. The new value is used by the next operation. With either bit at 0 the register is unchanged.
- R7: Increment register 0 always reads 1, and writes to it are ignored.
- R8: A write to index register 0 stores zero and clears its tag bit.
- R9: A register write (op_acc 0x3F, size 4 or 8) with sub-opcode 0 loads the descriptor base. With size 8 the base is data bits 47:0; with size 4 it is data bits 31:0, zero-extended. The write sets the access field to 3 and the tag field to 1 if op_tag is nonzero, else 0. No register write issues a store.
- R10: Sub-opcodes 1, 2 and 3 write data bits 31:0 to the current-index, index or increment register. The register number comes from the index field, masked to 3 bits for the increment file. Each write sets the register's tag bit to 1 when op_tag is nonzero. st_reg_tags reports these bits: bit 2 current index, bit 1 index, bit 0 increment.
- R11: A register write issued with opcode 0x1C or 0x1D changes no register.
- R12: With spec_mode 1 and probe_ok 0, the store is suppressed without raising an exception. The post-increment still follows R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 8 | Store opcode; selects the size |
| op_word | input | 32 | Operation word carrying the decoded fields |
| op_acc | input | 6 | Access code; 0x3F selects a register write |
| op_data | input | 64 | Store data or register-write data |
| op_tag | input | TAG_W | Tag of the data operand |
| cond_en | input | 1 | Evaluated post-increment condition |
| spec_mode | input | 1 | Speculative store |
| probe_ok | input | 1 | Write-permission probe result |
| lit_present | input | NUM_LIT | Literal slot present flags |
| lit_value | input | NUM_LIT*32 | Literal slot values |
| st_valid | output | 1 | Store request pulse |
| st_addr | output | 48 | Store address |
| st_data | output | 64 | Store data, masked to the size |
| st_size | output | 4 | Store size in bytes |
| st_desc_tag | output | 3 | Tag field of the descriptor used |
| st_desc_rw | output | 2 | Access field of the descriptor used |
| st_reg_tags | output | 3 | Tag bits of the current-index, index and increment registers used |
| st_ind | output | 32 | Index register selected by the index field |
| exc_illop | output | 1 | Illegal-operand exception pulse |

## Verification
Each result is due exactly one clock edge after the operation that causes it. The store request, its attributes and the exception come out of output registers, and the register files commit on that same edge. The bench drives each operation on a falling edge and samples just after the following rising edge. Effects on the register files are therefore visible to the operation issued immediately after. The bench confirms each register write and each increment through the address and attributes of a later store, and it never reads state inside the design.

// File: rtl/aau_pkg.sv
package aau_pkg;
  localparam int ADDR_W = 48;
  localparam int IDX_W  = 32;
  localparam int DATA_W = 64;

  typedef enum logic [1:0] {SUB_DESC = 2'd0, SUB_STI = 2'd1, SUB_IND = 2'd2, SUB_INCR = 2'd3} aau_sub_e;

  typedef struct packed {
    logic [4:0] desc_n;
    logic [3:0] idx_n;
    logic [2:0] incr_n;
    aau_sub_e   sub;
    logic [1:0] lit_sel;
  } aau_fields_t;

  function automatic aau_fields_t f_fields(input logic [31:0] w);
    aau_fields_t f;
    f.lit_sel = w[9:8];
    f.sub     = aau_sub_e'(w[11:10]);
    f.incr_n  = w[14:12];
    f.idx_n   = w[18:15];
    f.desc_n  = w[23:19];
    return f;
  endfunction

  function automatic logic [3:0] f_size(input logic [7:0] opc);
    case (opc)
      8'h1C:   return 4'd1;
      8'h1D:   return 4'd2;
      8'h1E:   return 4'd4;
      8'h1F:   return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] f_ea(input logic [ADDR_W-1:0] base,
                                             input logic [IDX_W-1:0] sti,
                                             input logic [31:0] lit);
    return base + {{(ADDR_W-IDX_W){sti[IDX_W-1]}}, sti} + {{(ADDR_W-32){1'b0}}, lit};
  endfunction

  function automatic logic [IDX_W-1:0] f_step(input logic [IDX_W-1:0] sti,
                                              input logic [IDX_W-1:0] incr,
                                              input logic [3:0] size);
    return sti + incr * {{(IDX_W-4){1'b0}}, size};
  endfunction

  function automatic logic [DATA_W-1:0] f_mask(input logic [DATA_W-1:0] d, input logic [3:0] size);
    case (size)
      4'd1:    return {56'b0, d[7:0]};
      4'd2:    return {48'b0, d[15:0]};
      4'd4:    return {32'b0, d[31:0]};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/aau_reg_file.sv
module aau_reg_file #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  parameter int MODE  = 0,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          wtag_en,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          wtag,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  output logic          rtag
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] tags;
  logic             we_eff;
  logic [W-1:0]     wval;
  logic             wtag_eff;

  generate
    if (MODE == 1) begin : g_read_one
      assign we_eff   = we && (waddr != '0);
      assign wval     = wdata;
      assign wtag_eff = wtag;
      assign rdata    = (raddr == '0) ? W'(1) : mem[raddr];
      assign rtag     = (raddr == '0) ? 1'b0 : tags[raddr];
    end else if (MODE == 2) begin : g_write_zero
      assign we_eff   = we;
      assign wval     = (waddr == '0) ? '0 : wdata;
      assign wtag_eff = (waddr == '0) ? 1'b0 : wtag;
      assign rdata    = mem[raddr];
      assign rtag     = tags[raddr];
    end else begin : g_plain
      assign we_eff   = we;
      assign wval     = wdata;
      assign wtag_eff = wtag;
      assign rdata    = mem[raddr];
      assign rtag     = tags[raddr];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      tags <= '0;
    end else if (we_eff) begin
      mem[waddr] <= wval;
      if (wtag_en) tags[waddr] <= wtag_eff;
    end
  end
endmodule

// File: rtl/aau_desc_file.sv
module aau_desc_file #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 48,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [ADDR_W-1:0] wbase,
  input  logic              wtag,
  input  logic [AW-1:0]     raddr,
  output logic [ADDR_W-1:0] rbase,
  output logic [2:0]        rtag,
  output logic [1:0]        rrw
);
  logic [ADDR_W-1:0] base_q [DEPTH];
  logic [2:0]        tag_q  [DEPTH];
  logic [1:0]        rw_q   [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        base_q[i] <= '0;
        tag_q[i]  <= '0;
        rw_q[i]   <= '0;
      end
    end else if (we) begin
      base_q[waddr] <= wbase;
      tag_q[waddr]  <= {2'b00, wtag};
      rw_q[waddr]   <= 2'b11;
    end
  end

  assign rbase = base_q[raddr];
  assign rtag  = tag_q[raddr];
  assign rrw   = rw_q[raddr];
endmodule

// File: rtl/aau_store_unit.sv
module aau_store_unit
  import aau_pkg::*;
#(
  parameter int NUM_DESC = 32,
  parameter int NUM_STI  = 16,
  parameter int NUM_IND  = 16,
  parameter int NUM_INCR = 8,
  parameter int NUM_LIT  = 3,
  parameter int TAG_W    = 2,
  localparam int DESC_AW = $clog2(NUM_DESC),
  localparam int STI_AW  = $clog2(NUM_STI),
  localparam int IND_AW  = $clog2(NUM_IND),
  localparam int INCR_AW = $clog2(NUM_INCR)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [7:0]            op_code,
  input  logic [31:0]           op_word,
  input  logic [5:0]            op_acc,
  input  logic [DATA_W-1:0]     op_data,
  input  logic [TAG_W-1:0]      op_tag,
  input  logic                  cond_en,
  input  logic                  spec_mode,
  input  logic                  probe_ok,
  input  logic [NUM_LIT-1:0]    lit_present,
  input  logic [NUM_LIT*32-1:0] lit_value,
  output logic                  st_valid,
  output logic [ADDR_W-1:0]     st_addr,
  output logic [DATA_W-1:0]     st_data,
  output logic [3:0]            st_size,
  output logic [2:0]            st_desc_tag,
  output logic [1:0]            st_desc_rw,
  output logic [2:0]            st_reg_tags,
  output logic [IDX_W-1:0]      st_ind,
  output logic                  exc_illop
);
  aau_fields_t fld;
  logic [3:0]  sz;
  logic        is_rw, rw_eff, is_st, illop, st_go, st_fire, inc_fire;
  logic [1:0]  lit_slot;
  logic        lit_ok;
  logic [31:0] lit_val;
  logic        dtag;

  logic [ADDR_W-1:0] d_base;
  logic [2:0]        d_tag;
  logic [1:0]        d_rw;
  logic [IDX_W-1:0]  sti_val, ind_val, incr_val, sti_wdata;
  logic              sti_tag, ind_tag, incr_tag;
  logic [ADDR_W-1:0] ea;

  assign fld      = f_fields(op_word);
  assign sz       = f_size(op_code);
  assign dtag     = |op_tag;
  assign is_rw    = op_valid && (sz != 4'd0) && (op_acc == 6'h3F);
  assign rw_eff   = is_rw && (sz[2] || sz[3]);
  assign is_st    = op_valid && (sz != 4'd0) && (op_acc != 6'h3F);
  assign lit_slot = fld.lit_sel - 2'd1;
  assign lit_ok   = (fld.lit_sel == 2'd0) || lit_present[lit_slot];
  assign lit_val  = (fld.lit_sel == 2'd0) ? 32'd0 : lit_value[lit_slot*32 +: 32];
  assign illop    = is_st && !lit_ok;
  assign st_go    = is_st && lit_ok;
  assign st_fire  = st_go && !(spec_mode && !probe_ok);
  assign inc_fire = st_go && fld.sub[0] && cond_en;

  aau_desc_file #(.DEPTH(NUM_DESC), .ADDR_W(ADDR_W)) u_desc (
    .clk(clk), .rst_n(rst_n),
    .we(rw_eff && fld.sub == SUB_DESC),
    .waddr(fld.desc_n[DESC_AW-1:0]),
    .wbase(sz[3] ? op_data[ADDR_W-1:0] : {{(ADDR_W-32){1'b0}}, op_data[31:0]}),
    .wtag(dtag),
    .raddr(fld.desc_n[DESC_AW-1:0]),
    .rbase(d_base), .rtag(d_tag), .rrw(d_rw)
  );

  assign sti_wdata = inc_fire ? f_step(sti_val, incr_val, sz) : op_data[IDX_W-1:0];

  aau_reg_file #(.DEPTH(NUM_STI), .W(IDX_W), .MODE(0)) u_sti (
    .clk(clk), .rst_n(rst_n),
    .we((rw_eff && fld.sub == SUB_STI) || inc_fire),
    .wtag_en(!inc_fire),
    .waddr(fld.idx_n[STI_AW-1:0]), .wdata(sti_wdata), .wtag(dtag),
    .raddr(fld.idx_n[STI_AW-1:0]), .rdata(sti_val), .rtag(sti_tag)
  );

  aau_reg_file #(.DEPTH(NUM_IND), .W(IDX_W), .MODE(2)) u_ind (
    .clk(clk), .rst_n(rst_n),
    .we(rw_eff && fld.sub == SUB_IND), .wtag_en(1'b1),
    .waddr(fld.idx_n[IND_AW-1:0]), .wdata(op_data[IDX_W-1:0]), .wtag(dtag),
    .raddr(fld.idx_n[IND_AW-1:0]), .rdata(ind_val), .rtag(ind_tag)
  );

  aau_reg_file #(.DEPTH(NUM_INCR), .W(IDX_W), .MODE(1)) u_incr (
    .clk(clk), .rst_n(rst_n),
    .we(rw_eff && fld.sub == SUB_INCR), .wtag_en(1'b1),
    .waddr(fld.idx_n[INCR_AW-1:0]), .wdata(op_data[IDX_W-1:0]), .wtag(dtag),
    .raddr(fld.incr_n[INCR_AW-1:0]), .rdata(incr_val), .rtag(incr_tag)
  );

  assign ea = f_ea(d_base, sti_val, lit_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid    <= 1'b0;
      exc_illop   <= 1'b0;
      st_addr     <= '0;
      st_data     <= '0;
      st_size     <= '0;
      st_desc_tag <= '0;
      st_desc_rw  <= '0;
      st_reg_tags <= '0;
      st_ind      <= '0;
    end else begin
      st_valid  <= st_fire;
      exc_illop <= illop;
      if (st_fire) begin
        st_addr     <= ea;
        st_data     <= f_mask(op_data, sz);
        st_size     <= sz;
        st_desc_tag <= d_tag;
        st_desc_rw  <= d_rw;
        st_reg_tags <= {sti_tag, ind_tag, incr_tag};
        st_ind      <= ind_val;
      end
    end
  end
endmodule

// File: rtl/aau_checker.sv
module aau_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [5:0]  op_acc,
  input logic [31:0] op_word,
  input logic        spec_mode,
  input logic        probe_ok,
  input logic        st_valid,
  input logic [3:0]  st_size,
  input logic        exc_illop
);
  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(op_valid)); // R5
  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_illop |-> !st_valid); // R3
  AST_EXC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_illop |-> $past(op_valid && op_word[9:8] != 2'd0)); // R3
  AST_SIZE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $countones(st_size) == 1); // R4
  AST_REGWR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && op_acc == 6'h3F) |-> !st_valid); // R9
  AST_SPEC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(op_valid && spec_mode && !probe_ok) |-> !st_valid); // R12
endmodule

bind aau_store_unit aau_checker u_aau_checker (.*);

// File: tb/aau_store_unit_bench.sv
`timescale 1ns/1ps
module aau_store_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [7:0]  op_code;
  logic [31:0] op_word;
  logic [5:0]  op_acc;
  logic [63:0] op_data;
  logic [1:0]  op_tag;
  logic        cond_en, spec_mode, probe_ok;
  logic [2:0]  lit_present;
  logic [95:0] lit_value;
  logic        st_valid;
  logic [47:0] st_addr;
  logic [63:0] st_data;
  logic [3:0]  st_size;
  logic [2:0]  st_desc_tag;
  logic [1:0]  st_desc_rw;
  logic [2:0]  st_reg_tags;
  logic [31:0] st_ind;
  logic        exc_illop;

  always #2.5 clk = ~clk;

  aau_store_unit u_aau_store_unit (.*);

  int n_chk = 0;
  int n_fail = 0;

  logic [47:0] m_base [32];
  logic        m_dtag [32];
  logic [1:0]  m_rw   [32];
  logic [31:0] m_sti  [16];
  logic        m_stit [16];
  logic [31:0] m_ind  [16];
  logic        m_indt [16];
  logic [31:0] m_incr [8];
  logic        m_incrt[8];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkw(input logic [1:0] lit, input logic [1:0] sub,
                                      input logic [2:0] incr, input logic [3:0] idx,
                                      input logic [4:0] desc);
    return {8'b0, desc, idx, incr, sub, lit, 8'b0};
  endfunction

  task automatic drive(input logic [7:0] opc, input logic [31:0] w, input logic [5:0] acc,
                       input logic [63:0] d, input logic [1:0] tg,
                       input logic c, input logic s, input logic p);
    @(negedge clk);
    op_valid = 1'b1; op_code = opc; op_word = w; op_acc = acc; op_data = d;
    op_tag = tg; cond_en = c; spec_mode = s; probe_ok = p;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  task automatic regwr(input logic [7:0] opc, input logic [1:0] sub, input int num,
                       input logic [63:0] d, input logic [1:0] tg);
    logic [31:0] w;
    w = (sub == 2'd0) ? mkw(2'd0, 2'd0, 3'd0, 4'd0, 5'(num)) : mkw(2'd0, sub, 3'd0, 4'(num), 5'd0);
    drive(opc, w, 6'h3F, d, tg, 1'b1, 1'b0, 1'b1);
    chk("R9 no store on register write", {63'b0, st_valid}, 64'd0);
    if (opc == 8'h1E || opc == 8'h1F) begin
      case (sub)
        2'd0: begin
          m_base[num] = (opc == 8'h1F) ? d[47:0] : {16'b0, d[31:0]};
          m_dtag[num] = |tg;
          m_rw[num]   = 2'b11;
        end
        2'd1: begin m_sti[num] = d[31:0]; m_stit[num] = |tg; end
        2'd2: begin
          m_ind[num]  = (num == 0) ? 32'd0 : d[31:0];
          m_indt[num] = (num == 0) ? 1'b0 : |tg;
        end
        default: if ((num % 8) != 0) begin
          m_incr[num % 8] = d[31:0]; m_incrt[num % 8] = |tg;
        end
      endcase
    end
  endtask

  task automatic store(input logic [7:0] opc, input logic [1:0] lit, input logic [1:0] sub,
                       input int incr, input int idx, input int desc, input logic [63:0] d,
                       input logic c, input logic s, input logic p);
    logic [3:0]  sz;
    logic        ill, fire;
    logic [31:0] litv, incv;
    logic [47:0] ea;
    logic [63:0] dm;
    sz   = 4'd1 << (opc - 8'h1C);
    ill  = (lit != 2'd0) && !lit_present[lit - 2'd1];
    fire = !ill && !(s && !p);
    litv = (lit == 2'd0) ? 32'd0 : lit_value[(lit - 2'd1)*32 +: 32];
    incv = (incr == 0) ? 32'd1 : m_incr[incr];
    ea   = m_base[desc] + {{16{m_sti[idx][31]}}, m_sti[idx]} + {16'b0, litv};
    dm   = (sz == 4'd1) ? {56'b0, d[7:0]} : (sz == 4'd2) ? {48'b0, d[15:0]} :
           (sz == 4'd4) ? {32'b0, d[31:0]} : d;
    drive(opc, mkw(lit, sub, 3'(incr), 4'(idx), 5'(desc)), 6'h00, d, 2'b00, c, s, p);
    chk("R3 exception flag", {63'b0, exc_illop}, {63'b0, ill});
    chk("R5 R12 store pulse", {63'b0, st_valid}, {63'b0, fire});
    if (fire) begin
      chk("R2 R6 address", {16'b0, st_addr}, {16'b0, ea});
      chk("R4 size", {60'b0, st_size}, {60'b0, sz});
      chk("R4 data mask", st_data, dm);
      chk("R9 descriptor tag field", {61'b0, st_desc_tag}, {63'b0, m_dtag[desc]});
      chk("R9 descriptor access field", {62'b0, st_desc_rw}, {62'b0, m_rw[desc]});
      chk("R10 register tags", {61'b0, st_reg_tags},
          {61'b0, m_stit[idx], m_indt[idx], (incr == 0) ? 1'b0 : m_incrt[incr]});
      chk("R8 R10 index value", {32'b0, st_ind}, {32'b0, m_ind[idx]});
    end
    if (!ill && sub[0] && c) m_sti[idx] = m_sti[idx] + incv * {28'b0, sz};
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_base[i] = '0; m_dtag[i] = 1'b0; m_rw[i] = 2'b00; end
    for (int i = 0; i < 16; i++) begin m_sti[i] = '0; m_stit[i] = 1'b0; m_ind[i] = '0; m_indt[i] = 1'b0; end
    for (int i = 0; i < 8; i++) begin m_incr[i] = '0; m_incrt[i] = 1'b0; end
    rst_n = 1'b0; op_valid = 1'b0; op_code = 8'h00; op_word = '0; op_acc = '0; op_data = '0;
    op_tag = '0; cond_en = 1'b0; spec_mode = 1'b0; probe_ok = 1'b1;
    lit_present = 3'b011;
    lit_value = {32'h1234_5678, 32'h8000_0004, 32'h0000_1111};
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset st_valid", {63'b0, st_valid}, 64'd0);
    chk("R1 reset exc_illop", {63'b0, exc_illop}, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    store(8'h1F, 2'd0, 2'd1, 0, 0, 0, 64'h1122_3344_5566_7788, 1'b1, 1'b0, 1'b1);
    chk("R1 reset address", {16'b0, st_addr}, 64'd0);
    store(8'h1F, 2'd0, 2'd0, 0, 0, 0, 64'h0, 1'b1, 1'b0, 1'b1);
    chk("R7 increment register 0 reads one", {16'b0, st_addr}, 64'd8);

    for (int i = 0; i < 32; i++)
      regwr((i % 2 == 0) ? 8'h1F : 8'h1E, 2'd0, i,
            64'hABCD_7000_0000_0000 ^ (64'(i) * 64'h0001_2345_6789), 2'(i % 3));
    for (int i = 0; i < 16; i++)
      regwr(8'h1E, 2'd1, i, (i % 2 == 1) ? 64'(32'hFFFF_F000 + i) : 64'(i * 32'h0100_0010), 2'(i % 4));
    for (int i = 0; i < 16; i++)
      regwr(8'h1F, 2'd2, i, 64'h5555_0000_A000_0000 + 64'(i), 2'b01);
    for (int i = 0; i < 8; i++)
      regwr(8'h1E, 2'd3, i, 64'(i + 2), 2'(i % 2));
    regwr(8'h1E, 2'd3, 8, 64'd99, 2'b01);

    regwr(8'h1C, 2'd0, 5, 64'hFFFF_FFFF_FFFF_FFFF, 2'b01);
    regwr(8'h1D, 2'd1, 3, 64'h0000_0000_DEAD_BEEF, 2'b01);
    store(8'h1F, 2'd0, 2'd0, 1, 3, 5, 64'h0, 1'b0, 1'b0, 1'b1);
    chk("R11 narrow register write ignored",
        {16'b0, st_addr}, {16'b0, m_base[5] + {{16{m_sti[3][31]}}, m_sti[3]}});

    drive(8'h1B, mkw(2'd0, 2'd1, 3'd2, 4'd4, 5'd1), 6'h00, 64'h1, 2'b00, 1'b1, 1'b0, 1'b1);
    chk("R4 unknown opcode no store", {63'b0, st_valid}, 64'd0);
    chk("R4 unknown opcode no exception", {63'b0, exc_illop}, 64'd0);
    store(8'h1F, 2'd0, 2'd0, 2, 4, 1, 64'h0, 1'b0, 1'b0, 1'b1);

    for (int idx = 0; idx < 16; idx++)
      for (int inc = 0; inc < 8; inc++)
        for (int s = 0; s < 4; s++)
          for (int c = 0; c < 2; c++)
            store(8'h1C + 8'(s), 2'((idx + inc + s) % 4), 2'((inc + c + s) % 2 == 0 ? 1 : 0),
                  inc, idx, (idx * 3 + inc) % 32,
                  64'hF1E2_D3C4_B5A6_9788 ^ 64'(idx * 131 + inc * 17 + s),
                  1'(c), inc == 5, 1'((idx + c) % 2));

    summary();
    $finish;
  end
endmodule